// File: doc/BRIEF.md
# Status-register write guard with address-zone locking

This block keeps the protection state of a small byte-addressed nonvolatile memory and decides, cycle by cycle, whether a write may go ahead. It holds three pieces of state: a write-arm latch, a guard-enable bit that makes an external guard pin effective, and a two-bit zone code that locks the top quarter, the top half or the whole of the address space. It presents a readable status byte and two permits. One permit is for changing the protection state itself. The other is for the array byte currently on the address input.

The serial front end feeds the block decoded strobes. These are arm, disarm, end of a write cycle, and a status write that carries its data byte. The front end also passes the busy flag of the write engine and the target address. It reads the status byte and the permits back. Both permits and the status byte depend only on present inputs and stored state, so the front end can sample them in the same cycle it presents an address. The bits that would be nonvolatile are ordinary registers with reset values set by parameters.

Top module: `wpu_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the arm latch, guard-enable bit and zone code are all 0, so the status byte reads 0x00 and both permits are 0.
- R2: A cycle with `wren_set` high and neither `wren_clr` nor `wr_done` high sets the arm latch at that clock edge.
- R3: `wren_clr` or `wr_done` clears the arm latch at that clock edge, and either of them wins over a simultaneous `wren_set`.
- R4: When `write_busy` is 0, the status byte is {guard-enable, 3'b000, zone[1:0], arm, 1'b0}. That is: bit 7 is guard-enable, bits 6..4 are 0, bits 3..2 are the zone code, bit 1 is the arm latch and bit 0 is 0.
- R5: When `write_busy` is 1, the status byte reads 0xFF whatever the stored state.
- R6: A status write accepted at a clock edge loads guard-enable from data bit 7 and the zone code from data bits 3..2. All other data bits are ignored, and the arm latch is not changed by the write.
- R7: `sr_write_ok` is 1 exactly when the arm latch is set and the hardware guard is not active. The hardware guard is active when guard-enable is 1 and `hw_guard_n` is 0. A status strobe with `sr_write_ok` at 0 changes nothing, so guard-enable cannot be cleared while the pin stays low.
- R8: Zone code 0 locks no address. Code 1 locks addresses with both top bits set (0x600..0x7FF at 11 bits). Code 2 locks addresses with the top bit set (0x400..0x7FF). Code 3 locks every address.
- R9: `arr_write_ok` is 1 exactly when the arm latch is set and `arr_addr` lies outside the locked zone. It does not depend on `hw_guard_n` or guard-enable.
- R10: Both permits follow a change of `arr_addr` or `hw_guard_n` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_guard_n | input | 1 | Guard pin, low requests hardware protection |
| wren_set | input | 1 | Arm strobe |
| wren_clr | input | 1 | Disarm strobe |
| wr_done | input | 1 | Pulse at the end of any array or status write cycle |
| sr_wr_strobe | input | 1 | Status write request carrying `sr_wr_data` |
| sr_wr_data | input | 8 | Status write data byte |
| write_busy | input | 1 | Write engine busy flag |
| arr_addr | input | ADDR_W | Target array byte address |
| status_byte | output | 8 | Readable status byte |
| sr_write_ok | output | 1 | Permit for a status write |
| arr_write_ok | output | 1 | Permit for a write to `arr_addr` |

## Verification
A wrong stored value appears at the status byte on the first idle cycle after the clock edge that caused it. A wrong zone code or arm latch also shows in `arr_write_ok` as soon as an address in the affected zone is presented. The bench sweeps every address under every zone code, arm state, guard-enable value and pin level. A decode slip at any zone boundary therefore appears within one address step. Status writes are attempted with the guard active, and the status byte is read back in the next cycle. A write that should have been refused is seen one edge after it happens.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  localparam int STAT_W     = 8;
  localparam int BIT_GUARD  = 7;
  localparam int BIT_ZONE_H = 3;
  localparam int BIT_ZONE_L = 2;
  localparam int BIT_ARM    = 1;

  typedef enum logic [1:0] {
    ZONE_NONE    = 2'b00,
    ZONE_QUARTER = 2'b01,
    ZONE_HALF    = 2'b10,
    ZONE_ALL     = 2'b11
  } zone_e;

  typedef struct packed {
    logic  guard_en;
    zone_e zone;
    logic  arm;
  } prot_state_t;

endpackage

// File: rtl/wpu_wel_latch.sv
module wpu_wel_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  output logic arm_q
);

  logic clear_any;
  assign clear_any = clr_i | done_i;

  always_ff @(posedge clk) begin
    if (rst)            arm_q <= 1'b0;
    else if (clear_any) arm_q <= 1'b0;
    else if (set_i)     arm_q <= 1'b1;
  end

endmodule

// File: rtl/wpu_status_regs.sv
module wpu_status_regs
  import wpu_pkg::*;
#(
  parameter logic  RST_GUARD = 1'b0,
  parameter zone_e RST_ZONE  = ZONE_NONE
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load_i,
  input  logic  guard_d,
  input  zone_e zone_d,
  output logic  guard_q,
  output zone_e zone_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q <= RST_GUARD;
      zone_q  <= RST_ZONE;
    end else if (load_i) begin
      guard_q <= guard_d;
      zone_q  <= zone_d;
    end
  end

endmodule

// File: rtl/wpu_zone_decode.sv
module wpu_zone_decode
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  zone_e             zone_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);

  localparam int TOP = ADDR_W - 1;

  logic top_half;
  logic top_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_half    = addr_i[TOP];
      assign top_quarter = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign top_half    = addr_i[TOP];
      assign top_quarter = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    case (zone_i)
      ZONE_NONE:    locked_o = 1'b0;
      ZONE_QUARTER: locked_o = top_quarter;
      ZONE_HALF:    locked_o = top_half;
      default:      locked_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
#(
  parameter int    ADDR_W    = 11,
  parameter logic  RST_GUARD = 1'b0,
  parameter zone_e RST_ZONE  = ZONE_NONE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_guard_n,
  input  logic              wren_set,
  input  logic              wren_clr,
  input  logic              wr_done,
  input  logic              sr_wr_strobe,
  input  logic [7:0]        sr_wr_data,
  input  logic              write_busy,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        status_byte,
  output logic              sr_write_ok,
  output logic              arr_write_ok
);

  logic  wel_q;
  logic  guard_q;
  zone_e zone_q;
  logic  hw_active;
  logic  sr_load;
  logic  zone_locked;
  logic  unused_data;

  assign unused_data = ^{sr_wr_data[6:4], sr_wr_data[1:0]};

  wpu_wel_latch u_wel (
    .clk    (clk),
    .rst    (rst),
    .set_i  (wren_set),
    .clr_i  (wren_clr),
    .done_i (wr_done),
    .arm_q  (wel_q)
  );

  assign hw_active   = guard_q & ~hw_guard_n;
  assign sr_write_ok = wel_q & ~hw_active;
  assign sr_load     = sr_wr_strobe & sr_write_ok;

  wpu_status_regs #(
    .RST_GUARD (RST_GUARD),
    .RST_ZONE  (RST_ZONE)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .load_i  (sr_load),
    .guard_d (sr_wr_data[BIT_GUARD]),
    .zone_d  (zone_e'(sr_wr_data[BIT_ZONE_H:BIT_ZONE_L])),
    .guard_q (guard_q),
    .zone_q  (zone_q)
  );

  wpu_zone_decode #(
    .ADDR_W (ADDR_W)
  ) u_zone (
    .zone_i   (zone_q),
    .addr_i   (arr_addr),
    .locked_o (zone_locked)
  );

  assign arr_write_ok = wel_q & ~zone_locked;

  always_comb begin
    if (write_busy) begin
      status_byte = '1;
    end else begin
      status_byte                        = '0;
      status_byte[BIT_GUARD]             = guard_q;
      status_byte[BIT_ZONE_H:BIT_ZONE_L] = zone_q;
      status_byte[BIT_ARM]               = wel_q;
    end
  end

endmodule

// File: rtl/wpu_checker.sv
module wpu_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_guard_n,
  input logic              wren_set,
  input logic              wren_clr,
  input logic              wr_done,
  input logic              sr_wr_strobe,
  input logic              write_busy,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [7:0]        status_byte,
  input logic              sr_write_ok,
  input logic              arr_write_ok,
  input logic              wel_q,
  input logic              guard_q,
  input logic [1:0]        zone_q
);

  logic unused_addr;
  assign unused_addr = ^arr_addr;

  a_r2_arm_sets: assert property (@(posedge clk) disable iff (rst)
    (wren_set && !wren_clr && !wr_done) |=> wel_q);

  a_r3_arm_clears: assert property (@(posedge clk) disable iff (rst)
    (wren_clr || wr_done) |=> !wel_q);

  a_r4_idle_layout: assert property (@(posedge clk) disable iff (rst)
    !write_busy |-> (status_byte[6:4] == 3'b000 && status_byte[0] == 1'b0));

  a_r5_busy_all_ones: assert property (@(posedge clk) disable iff (rst)
    write_busy |-> (status_byte == 8'hFF));

  a_r7_guard_blocks: assert property (@(posedge clk) disable iff (rst)
    (guard_q && !hw_guard_n) |-> !sr_write_ok);

  a_r7_refused_holds: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_strobe && !sr_write_ok) |=> ($stable(guard_q) && $stable(zone_q)));

  a_r8_all_locked: assert property (@(posedge clk) disable iff (rst)
    (zone_q == 2'b11) |-> !arr_write_ok);

  a_r9_needs_arm: assert property (@(posedge clk) disable iff (rst)
    !wel_q |-> (!arr_write_ok && !sr_write_ok));

endmodule

bind wpu_top wpu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .hw_guard_n   (hw_guard_n),
  .wren_set     (wren_set),
  .wren_clr     (wren_clr),
  .wr_done      (wr_done),
  .sr_wr_strobe (sr_wr_strobe),
  .write_busy   (write_busy),
  .arr_addr     (arr_addr),
  .status_byte  (status_byte),
  .sr_write_ok  (sr_write_ok),
  .arr_write_ok (arr_write_ok),
  .wel_q        (wel_q),
  .guard_q      (guard_q),
  .zone_q       (zone_q)
);

// File: tb/wpu_top_tb_top.sv
module wpu_top_tb_top;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hw_guard_n = 1'b1;
  logic          wren_set = 1'b0, wren_clr = 1'b0, wr_done = 1'b0;
  logic          sr_wr_strobe = 1'b0;
  logic [7:0]    sr_wr_data = 8'h00;
  logic          write_busy = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [7:0]    status_byte;
  logic          sr_write_ok, arr_write_ok;

  int n_chk = 0;
  int n_bad = 0;

  logic       m_wel = 1'b0;
  logic       m_guard = 1'b0;
  logic [1:0] m_zone = 2'b00;

  always #2 clk = ~clk;

  wpu_top #(.ADDR_W(AW)) dut_i (
    .clk (clk), .rst (rst), .hw_guard_n (hw_guard_n),
    .wren_set (wren_set), .wren_clr (wren_clr), .wr_done (wr_done),
    .sr_wr_strobe (sr_wr_strobe), .sr_wr_data (sr_wr_data),
    .write_busy (write_busy), .arr_addr (arr_addr),
    .status_byte (status_byte), .sr_write_ok (sr_write_ok),
    .arr_write_ok (arr_write_ok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic locked(input logic [1:0] z, input logic [AW-1:0] a);
    case (z)
      2'd0: return 1'b0;
      2'd1: return a[AW-1] & a[AW-2];
      2'd2: return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat(input logic busy);
    return busy ? 8'hFF : {m_guard, 3'b000, m_zone, m_wel, 1'b0};
  endfunction

  // check current outputs against the model, without clocking
  task automatic check_now(input string stag);
    chk(stag, status_byte, exp_stat(write_busy));
    chk("R7", {7'd0, sr_write_ok}, {7'd0, m_wel & ~(m_guard & ~hw_guard_n)});
    chk("R9", {7'd0, arr_write_ok}, {7'd0, m_wel & ~locked(m_zone, arr_addr)});
  endtask

  task automatic step(input logic set, input logic clr, input logic done,
                      input logic srw, input logic [7:0] d, input logic pin,
                      input logic busy, input string stag);
    logic ok;
    @(negedge clk);
    wren_set = set; wren_clr = clr; wr_done = done;
    sr_wr_strobe = srw; sr_wr_data = d; hw_guard_n = pin; write_busy = busy;
    #1;
    check_now(stag);
    ok = m_wel & ~(m_guard & ~pin);
    @(posedge clk);
    if (srw && ok) begin m_guard = d[7]; m_zone = d[3:2]; end
    if (clr || done) m_wel = 1'b0;
    else if (set) m_wel = 1'b1;
  endtask

  task automatic idle(input string stag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, hw_guard_n, 1'b0, stag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    m_wel = 1'b0; m_guard = 1'b0; m_zone = 2'b00;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", status_byte, 8'h00);
    chk("R1", {6'd0, sr_write_ok, arr_write_ok}, 8'h00);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset();

    // R2 arm, R3 disarm, clear wins over set, done clears
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R2");
    idle("R2");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
    idle("R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
    idle("R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
    idle("R3");

    // sweep zone, guard-enable, arm and pin over every address
    for (int z = 0; z < 4; z++) begin
      for (int g = 0; g < 2; g++) begin
        for (int w = 0; w < 2; w++) begin
          for (int p = 0; p < 2; p++) begin
            // program with pin high; noise in ignored data bits (R6)
            step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R2");
            step(1'b0, 1'b0, 1'b0, 1'b1, {g[0], 3'b111, z[1:0], 2'b11}, 1'b1, 1'b0, "R6");
            idle("R6");
            chk("R6", status_byte, {g[0], 3'b000, z[1:0], 1'b1, 1'b0});
            if (w == 0) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
            @(negedge clk);
            hw_guard_n = p[0];
            for (int a = 0; a < (1 << AW); a++) begin
              arr_addr = a[AW-1:0];
              #1;
              chk("R8 R10", {7'd0, arr_write_ok},
                  {7'd0, m_wel & ~locked(m_zone, arr_addr)});
            end
            // R7: attempt to flip every protection bit under this pin level
            step(1'b0, 1'b0, 1'b0, 1'b1, {~g[0], 3'b000, ~z[1:0], 2'b00},
                 p[0], 1'b0, "R7");
            idle("R7");
            // R5: busy masks the byte
            step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, p[0], 1'b1, "R5");
          end
        end
      end
    end

    // R7: guard-enable stays set while the pin is low, even when armed
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R7");
    idle("R7");
    chk("R7", status_byte, 8'h82);

    // R1: reset from a non-zero state
    do_reset();
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule